// File: doc/BRIEF.md
# External Bus Port-Sizing Master

The block is a bus-cycle engine that sits between an internal requester and an external memory bus. It accepts one request at a time. A request carries an address, a direction, an operand size (byte, word, longword or four-longword line) and 32 bits of write data. The engine turns the request into one or more external beats. The number of beats and the byte lanes used follow from the operand size and from the width programmed for the region being accessed (8, 16 or 32 bits).

Narrow ports always sit on the upper lanes of the data bus. Wide operands are cut into beats from the most significant byte downwards, and the address steps by the beat width. Each beat ends in one of two ways: after a programmed number of wait clocks when internal termination is on, or when the slave pulls its acknowledge low. For reads, the bytes gathered from all beats are assembled into one 32-bit result. The result is returned with a one-cycle done pulse. Address, size attribute, direction, write data and the start strobe change on the rising clock edge. The address strobe, chip select, output enable and byte enables change on the falling edge.

Top module: `xbus_sizer`

## Requirements
- R1: The size attribute uses 00 = longword, 01 = byte, 10 = word, 11 = line. On the first beat of every access it shows the requested operand size.
- R2: With bursting on (cfgBurst=1), every beat shows the operand size. With bursting off, every beat after the first shows the port code: 01 for 8 bits, 10 for 16 bits, 00 for 32 bits. The port width input uses that same code, and 11 is treated as 32 bits.
- R3: The beat width is the smaller of the operand width and the port width. A line counts as four longwords. The number of beats is the operand bytes divided by the beat width. Beat k drives the request address plus k times the beat width.
- R4: beN[0] enables D[31:24] and beN[3] enables D[7:0], active low. The enabled lanes start at lane (address modulo port bytes) and cover beat-width lanes. All four are high while idle.
- R5: Write data is laid out big-endian by address. The byte for address offset o (address bits 1:0) is reqWdata[31-8o -: 8]. Each beat presents its bytes on the enabled lanes. A line write stores the same 32-bit word into each of its four longwords.
- R6: A read result holds each accessed byte at its address-offset position and zero in all other bytes. For a line, the result is the final longword.
- R7: With internal termination on (cfgAutoAck=1), every beat lasts exactly cfgWaits+1 clocks, and extAckN has no effect.
- R8: With internal termination off, a beat ends on the first rising edge at which extAckN is sampled low.
- R9: tsN is low for exactly one clock, the first clock of each access, and high on all later beats.
- R10: asN and csN go low on the falling edge after the request is accepted. They stay low through the last beat and rise on the falling edge after it. oeN is low under the same timing for reads only.
- R11: done pulses high for one clock right after the final beat, and doneRdata is valid in that cycle. A request is taken only while busy is low. Requests raised during an access are dropped.
- R12: After reset, tsN, asN, csN and oeN are high, beN is 4'hF, and busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe, taken when idle |
| reqAddr | input | ADDR_W | Request byte address (aligned) |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 2 | Operand size code |
| reqWdata | input | 32 | Write data, big-endian by address |
| cfgPortW | input | 2 | Region port width code |
| cfgWaits | input | WAIT_W | Wait clocks per beat for internal termination |
| cfgAutoAck | input | 1 | 1 = internal termination |
| cfgBurst | input | 1 | 1 = bursting allowed |
| extAckN | input | 1 | External acknowledge, active low |
| busRdata | input | 32 | External read data |
| busAddr | output | ADDR_W | External address |
| busSize | output | 2 | Size attribute |
| busWrite | output | 1 | Direction attribute |
| busWdata | output | 32 | External write data |
| tsN | output | 1 | Transfer start, active low |
| asN | output | 1 | Address strobe, active low |
| csN | output | 1 | Chip select, active low |
| oeN | output | 1 | Output enable, active low |
| beN | output | 4 | Byte enables, active low |
| busy | output | 1 | Access in progress |
| done | output | 1 | Access complete pulse |
| doneRdata | output | 32 | Assembled read data |

## Verification
The two functions that can meet in one cycle are completion of one access and acceptance of the next. The done pulse occupies the cycle in which the engine is idle again, so a request raised in that same cycle must be taken at the following edge. The bench issues every table vector in the done cycle of the previous one. It then checks that the earlier result is intact and that the new access starts with its own first-beat address, size and start strobe. A second, directed case raises a request in the middle of an access. It judges that no extra done pulse, busy cycle or strobe appears and that the original read result is returned.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [1:0] {
    SZ_LONG = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_WORD = 2'b10,
    SZ_LINE = 2'b11
  } xsize_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BEAT = 1'b1
  } xstate_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // request accepted
    logic step;     // beat ended, another follows
    logic capture;  // beat ended, sample read lanes
    logic finish;   // final beat ended
  } xstrobe_t;

  // bytes covered by a size or port-width code
  function automatic logic [2:0] codeBytes(input logic [1:0] code);
    case (code)
      2'b01:   codeBytes = 3'd1;
      2'b10:   codeBytes = 3'd2;
      default: codeBytes = 3'd4;
    endcase
  endfunction

  // size code shown for a port width on later unburst beats
  function automatic logic [1:0] portCode(input logic [1:0] pw);
    portCode = (pw == 2'b11) ? 2'b00 : pw;
  endfunction

  function automatic logic [2:0] minBytes(input logic [2:0] a, input logic [2:0] b);
    minBytes = (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int WAIT_W     = 4,
  parameter int LINE_LONGS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqSize,
  input  logic [1:0]        cfgPortW,
  input  logic [WAIT_W-1:0] cfgWaits,
  input  logic              cfgAutoAck,
  input  logic              extAckN,
  output xstrobe_t          strb,
  output logic              busy,
  output logic              tsN,
  output logic              done
);

  localparam int BEAT_W = $clog2(LANES * LINE_LONGS + 1);

  xstate_e             state;
  logic [WAIT_W-1:0]   waitCnt;
  logic [WAIT_W-1:0]   waitsQ;
  logic                autoQ;
  logic [BEAT_W-1:0]   beatLeft;
  logic [BEAT_W-1:0]   beatTotal;
  logic [2:0]          opBytes;
  logic [2:0]          beatBytes;
  logic [2:0]          perLong;
  logic                beatEnd;

  always_comb begin
    opBytes   = codeBytes(reqSize);
    beatBytes = minBytes(opBytes, codeBytes(cfgPortW));
    case (beatBytes)
      3'd1:    perLong = opBytes;
      3'd2:    perLong = opBytes >> 1;
      default: perLong = 3'd1;
    endcase
    if (reqSize == SZ_LINE)
      beatTotal = BEAT_W'(int'(perLong) * LINE_LONGS);
    else
      beatTotal = BEAT_W'(perLong);
  end

  assign busy    = (state == ST_BEAT);
  assign beatEnd = busy && (autoQ ? (waitCnt == waitsQ) : !extAckN);

  always_comb begin
    strb.load    = !busy && reqValid;
    strb.capture = beatEnd;
    strb.finish  = beatEnd && (beatLeft == BEAT_W'(1));
    strb.step    = beatEnd && (beatLeft != BEAT_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      waitCnt  <= '0;
      waitsQ   <= '0;
      autoQ    <= 1'b0;
      beatLeft <= '0;
      tsN      <= 1'b1;
      done     <= 1'b0;
    end else begin
      tsN  <= !strb.load;
      done <= strb.finish;
      if (strb.load) begin
        state    <= ST_BEAT;
        waitCnt  <= '0;
        waitsQ   <= cfgWaits;
        autoQ    <= cfgAutoAck;
        beatLeft <= beatTotal;
      end else if (beatEnd) begin
        waitCnt <= '0;
        if (strb.finish) state <= ST_IDLE;
        else             beatLeft <= beatLeft - BEAT_W'(1);
      end else if (busy && (waitCnt != '1)) begin
        waitCnt <= waitCnt + WAIT_W'(1);
      end
    end
  end

endmodule

// File: rtl/xbus_dpath.sv
module xbus_dpath
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  xstrobe_t          strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [1:0]        cfgPortW,
  input  logic              cfgBurst,
  input  logic [DATA_W-1:0] busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busSize,
  output logic              busWrite,
  output logic [DATA_W-1:0] busWdata,
  output logic [LANES-1:0]  laneMask,
  output logic [DATA_W-1:0] doneRdata
);

  logic [ADDR_W-1:0] addrQ;
  logic [1:0]        sizeQ;
  logic [1:0]        portQ;
  logic              burstQ;
  logic              writeQ;
  logic [DATA_W-1:0] wdataQ;
  logic [1:0]        sizeOutQ;
  logic [DATA_W-1:0] accQ;
  logic [DATA_W-1:0] rdQ;

  logic [2:0]        portBytes;
  logic [2:0]        beatBytes;
  logic [1:0]        offset;
  logic [1:0]        laneStart;
  logic [1:0]        laneShift;
  logic [4:0]        shiftBits;
  logic [DATA_W-1:0] rdShift;
  logic [DATA_W-1:0] accNext;
  logic [LANES-1:0]  opMask;

  always_comb begin
    portBytes = codeBytes(portQ);
    beatBytes = minBytes(codeBytes(sizeQ), portBytes);
    offset    = addrQ[1:0];
    laneStart = offset & 2'(portBytes - 3'd1);
    laneShift = offset - laneStart;
    shiftBits = {laneShift, 3'b000};
    rdShift   = busRdata >> shiftBits;
  end

  // lane and operand-byte windows, index 0 = most significant byte
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [2:0] IDX = 3'(i);
    assign laneMask[i] = (IDX >= {1'b0, laneStart}) && (IDX < ({1'b0, laneStart} + beatBytes));
    assign opMask[i]   = (IDX >= {1'b0, offset})    && (IDX < ({1'b0, offset} + beatBytes));
    assign accNext[DATA_W-1-8*i -: 8] = opMask[i] ? rdShift[DATA_W-1-8*i -: 8]
                                                  : accQ[DATA_W-1-8*i -: 8];
  end

  assign busAddr   = addrQ;
  assign busSize   = sizeOutQ;
  assign busWrite  = writeQ;
  assign busWdata  = writeQ ? (wdataQ << shiftBits) : '0;
  assign doneRdata = rdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      sizeQ    <= '0;
      portQ    <= '0;
      burstQ   <= 1'b0;
      writeQ   <= 1'b0;
      wdataQ   <= '0;
      sizeOutQ <= '0;
      accQ     <= '0;
      rdQ      <= '0;
    end else if (strb.load) begin
      addrQ    <= reqAddr;
      sizeQ    <= reqSize;
      portQ    <= cfgPortW;
      burstQ   <= cfgBurst;
      writeQ   <= reqWrite;
      wdataQ   <= reqWdata;
      sizeOutQ <= reqSize;
      accQ     <= '0;
    end else begin
      if (strb.capture && !writeQ) accQ <= accNext;
      if (strb.finish && !writeQ)  rdQ  <= accNext;
      if (strb.step) begin
        addrQ    <= addrQ + ADDR_W'(beatBytes);
        sizeOutQ <= burstQ ? sizeQ : portCode(portQ);
      end
    end
  end

endmodule

// File: rtl/xbus_edge.sv
module xbus_edge
  import xbus_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             active,
  input  logic             writeQ,
  input  logic [LANES-1:0] laneMask,
  output logic             asN,
  output logic             csN,
  output logic             oeN,
  output logic [LANES-1:0] beN
);

  // strobes launched on the falling clock edge
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      asN <= 1'b1;
      csN <= 1'b1;
      oeN <= 1'b1;
      beN <= '1;
    end else begin
      asN <= !active;
      csN <= !active;
      oeN <= !(active && !writeQ);
      beN <= active ? ~laneMask : '1;
    end
  end

endmodule

// File: rtl/xbus_sizer.sv
module xbus_sizer
  import xbus_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WAIT_W     = 4,
  parameter int LINE_LONGS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [31:0]       reqWdata,
  input  logic [1:0]        cfgPortW,
  input  logic [WAIT_W-1:0] cfgWaits,
  input  logic              cfgAutoAck,
  input  logic              cfgBurst,
  input  logic              extAckN,
  input  logic [31:0]       busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busSize,
  output logic              busWrite,
  output logic [31:0]       busWdata,
  output logic              tsN,
  output logic              asN,
  output logic              csN,
  output logic              oeN,
  output logic [3:0]        beN,
  output logic              busy,
  output logic              done,
  output logic [31:0]       doneRdata
);

  xstrobe_t         strb;
  logic [LANES-1:0] laneMask;

  xbus_ctrl #(.WAIT_W(WAIT_W), .LINE_LONGS(LINE_LONGS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqSize    (reqSize),
    .cfgPortW   (cfgPortW),
    .cfgWaits   (cfgWaits),
    .cfgAutoAck (cfgAutoAck),
    .extAckN    (extAckN),
    .strb       (strb),
    .busy       (busy),
    .tsN        (tsN),
    .done       (done)
  );

  xbus_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqAddr   (reqAddr),
    .reqWrite  (reqWrite),
    .reqSize   (reqSize),
    .reqWdata  (reqWdata),
    .cfgPortW  (cfgPortW),
    .cfgBurst  (cfgBurst),
    .busRdata  (busRdata),
    .busAddr   (busAddr),
    .busSize   (busSize),
    .busWrite  (busWrite),
    .busWdata  (busWdata),
    .laneMask  (laneMask),
    .doneRdata (doneRdata)
  );

  xbus_edge u_edge (
    .clk      (clk),
    .rstN     (rstN),
    .active   (busy),
    .writeQ   (busWrite),
    .laneMask (laneMask),
    .asN      (asN),
    .csN      (csN),
    .oeN      (oeN),
    .beN      (beN)
  );

endmodule

// File: rtl/xbus_sizer_chk.sv
module xbus_sizer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       done,
  input logic       tsN,
  input logic       asN,
  input logic       csN,
  input logic       oeN,
  input logic       busWrite,
  input logic [3:0] beN
);

  // R9
  ts_single_chk: assert property (@(posedge clk) disable iff (!rstN) !tsN |=> tsN);

  // R9
  ts_busy_chk: assert property (@(posedge clk) disable iff (!rstN) !tsN |-> busy);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);

  // R11
  done_end_chk: assert property (@(posedge clk) disable iff (!rstN) $fell(busy) |-> done);

  // R10
  select_active_chk: assert property (@(posedge clk) disable iff (!rstN) busy |-> (!csN && !asN));

  // R10
  oe_write_chk: assert property (@(posedge clk) disable iff (!rstN) (busy && busWrite) |-> oeN);

  // R4
  lane_active_chk: assert property (@(posedge clk) disable iff (!rstN) busy |-> (beN != 4'hF));

endmodule

bind xbus_sizer xbus_sizer_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busy     (busy),
  .done     (done),
  .tsN      (tsN),
  .asN      (asN),
  .csN      (csN),
  .oeN      (oeN),
  .busWrite (busWrite),
  .beN      (beN)
);

// File: tb/xbus_sizer_tb.sv
`timescale 1ns/100ps
module xbus_sizer_tb;

  typedef struct packed {
    logic        wr;
    logic [1:0]  sz;
    logic [1:0]  pw;
    logic        burst;
    logic        selfEnd;
    logic [3:0]  dly;
    logic [5:0]  addr;
    logic [31:0] wd;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{wr:1'b0, sz:2'b00, pw:2'b01, burst:1'b0, selfEnd:1'b1, dly:4'd1, addr:6'h10, wd:32'h0},
    '{wr:1'b0, sz:2'b00, pw:2'b01, burst:1'b1, selfEnd:1'b1, dly:4'd0, addr:6'h14, wd:32'h0},
    '{wr:1'b0, sz:2'b00, pw:2'b10, burst:1'b0, selfEnd:1'b1, dly:4'd2, addr:6'h08, wd:32'h0},
    '{wr:1'b0, sz:2'b11, pw:2'b00, burst:1'b1, selfEnd:1'b1, dly:4'd0, addr:6'h20, wd:32'h0},
    '{wr:1'b0, sz:2'b11, pw:2'b00, burst:1'b0, selfEnd:1'b1, dly:4'd1, addr:6'h00, wd:32'h0},
    '{wr:1'b1, sz:2'b00, pw:2'b01, burst:1'b0, selfEnd:1'b0, dly:4'd3, addr:6'h04, wd:32'hA1B2C3D4},
    '{wr:1'b1, sz:2'b01, pw:2'b00, burst:1'b0, selfEnd:1'b1, dly:4'd0, addr:6'h0B, wd:32'h11223344},
    '{wr:1'b0, sz:2'b10, pw:2'b00, burst:1'b0, selfEnd:1'b0, dly:4'd1, addr:6'h1A, wd:32'h0},
    '{wr:1'b0, sz:2'b10, pw:2'b01, burst:1'b0, selfEnd:1'b1, dly:4'd0, addr:6'h2E, wd:32'h0},
    '{wr:1'b1, sz:2'b11, pw:2'b10, burst:1'b0, selfEnd:1'b1, dly:4'd0, addr:6'h30, wd:32'h5A6B7C8D},
    '{wr:1'b0, sz:2'b01, pw:2'b10, burst:1'b1, selfEnd:1'b0, dly:4'd0, addr:6'h25, wd:32'h0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqSize = '0;
  logic [31:0] reqWdata = '0;
  logic [1:0]  cfgPortW = '0;
  logic [3:0]  cfgWaits = '0;
  logic        cfgAutoAck = 1'b1;
  logic        cfgBurst = 1'b0;
  logic        extAckN = 1'b1;
  logic [31:0] busRdata;
  logic [31:0] busAddr;
  logic [1:0]  busSize;
  logic        busWrite;
  logic [31:0] busWdata;
  logic        tsN, asN, csN, oeN, busy, done;
  logic [3:0]  beN;
  logic [31:0] doneRdata;

  logic [7:0]  mem    [64];
  logic [7:0]  expMem [64];
  int          curPortB = 4;
  int          total = 0;
  int          bad = 0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;

  xbus_sizer u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqWdata(reqWdata), .cfgPortW(cfgPortW), .cfgWaits(cfgWaits),
    .cfgAutoAck(cfgAutoAck), .cfgBurst(cfgBurst), .extAckN(extAckN), .busRdata(busRdata),
    .busAddr(busAddr), .busSize(busSize), .busWrite(busWrite), .busWdata(busWdata),
    .tsN(tsN), .asN(asN), .csN(csN), .oeN(oeN), .beN(beN), .busy(busy), .done(done),
    .doneRdata(doneRdata)
  );

  // slave model: port lanes from lane 0 upward, unused lanes carry junk
  always_comb begin
    int base;
    busRdata = {4{8'hEE}};
    base = int'(busAddr[5:0]) & ~(curPortB - 1);
    for (int i = 0; i < curPortB; i++) busRdata[31-8*i -: 8] = mem[base + i];
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic nextSample();
    @(negedge clk);
    #0.5;
  endtask

  function automatic int bytesOf(input logic [1:0] code);
    return (code == 2'b01) ? 1 : (code == 2'b10) ? 2 : 4;
  endfunction

  // issued at a sample point; returns at the done cycle
  task automatic runVec(input int idx, input vec_t v);
    int opB, pB, bb, nb, len, ea, ls, start, off;
    logic [1:0]  es;
    logic [3:0]  eBe;
    logic [31:0] expRd;
    opB = bytesOf(v.sz);
    pB  = bytesOf(v.pw);
    bb  = (opB < pB) ? opB : pB;
    nb  = (opB / bb) * ((v.sz == 2'b11) ? 4 : 1);
    len = int'(v.dly) + 1;
    start = int'(v.addr) + ((v.sz == 2'b11) ? 12 : 0);
    off = start % 4;
    expRd = '0;
    for (int j = 0; j < 4; j++)
      if (j >= off && j < off + opB) expRd[31-8*j -: 8] = mem[(start & ~3) + j];
    for (int k = 0; k < 64; k++) expMem[k] = mem[k];
    if (v.wr)
      for (int k = 0; k < ((v.sz == 2'b11) ? 16 : opB); k++)
        expMem[int'(v.addr) + k] = v.wd[31-8*((int'(v.addr) + k) % 4) -: 8];

    curPortB   = pB;
    reqValid   = 1'b1;
    reqAddr    = {26'h0, v.addr};
    reqWrite   = v.wr;
    reqSize    = v.sz;
    reqWdata   = v.wd;
    cfgPortW   = v.pw;
    cfgWaits   = v.dly;
    cfgAutoAck = v.selfEnd;
    cfgBurst   = v.burst;
    nextSample();
    reqValid = 1'b0;
    for (int b = 0; b < nb; b++) begin
      ea  = int'(v.addr) + b * bb;
      es  = (b == 0 || v.burst) ? v.sz : ((v.pw == 2'b11) ? 2'b00 : v.pw);
      ls  = ea % pB;
      eBe = 4'hF;
      for (int i = ls; i < ls + bb; i++) eBe[i] = 1'b0;
      for (int c = 0; c < len; c++) begin
        if (c == 0)
          // R1 R2 R3 R4 R9 R10 R7 R8: beat address, size, lanes, strobes
          chk("R1 R2 R3 R4 R9 R10", $sformatf("vec%0d beat%0d", idx, b),
              {42'h0, busAddr[5:0], busSize, eBe ^ beN ^ eBe, tsN, asN, csN, oeN, busy},
              {42'h0, 6'(ea), es, eBe, (b != 0), 1'b0, 1'b0, v.wr, 1'b1});
        // R7: early ack ignored in self mode; R8: ack on last clock otherwise
        extAckN = v.selfEnd ? (c != 0) : (c != len - 1);
        if (c == len - 1 && v.wr)
          for (int i = 0; i < pB; i++)
            if (!beN[i]) mem[(ea & ~(pB - 1)) + i] = busWdata[31-8*i -: 8];
        nextSample();
      end
    end
    extAckN = 1'b1;
    // R11: done pulse, idle, strobes released
    chk("R11", $sformatf("vec%0d done", idx), {61'h0, done, busy, asN}, {61'h0, 1'b1, 1'b0, 1'b1});
    if (!v.wr) begin
      // R6: assembled read data
      chk("R6", $sformatf("vec%0d rdata", idx), {32'h0, doneRdata}, {32'h0, expRd});
    end else begin
      int mism = 0;
      for (int k = 0; k < 64; k++) if (mem[k] !== expMem[k]) mism++;
      // R5: bytes written through the lanes
      chk("R5", $sformatf("vec%0d mem mismatches", idx), 64'(mism), 64'h0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 64; k++) mem[k] = 8'(k * 37 + 5);
    repeat (3) nextSample();
    // R12: reset state
    chk("R12", "reset outputs", {55'h0, tsN, asN, csN, oeN, beN, busy, done},
        {55'h0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 1'b0, 1'b0});
    rstN = 1'b1;
    nextSample();
    chk("R12", "idle after release", {58'h0, beN, busy, done}, {58'h0, 4'hF, 1'b0, 1'b0});

    // table walk; each vector starts in the done cycle of the previous one
    for (int n = 0; n < NVEC; n++) runVec(n, VECS[n]);
    nextSample();

    // R10: falling-edge strobe launch and release
    curPortB = 4;
    reqValid = 1'b1; reqAddr = 32'h0; reqWrite = 1'b0; reqSize = 2'b00;
    cfgPortW = 2'b00; cfgWaits = 4'd0; cfgAutoAck = 1'b1; cfgBurst = 1'b0;
    @(posedge clk); #0.5;
    reqValid = 1'b0;
    chk("R10", "after rising edge", {61'h0, tsN, busy, asN}, {61'h0, 1'b0, 1'b1, 1'b1});
    @(negedge clk); #0.5;
    chk("R10", "after falling edge", {61'h0, asN, csN, oeN}, {61'h0, 1'b0, 1'b0, 1'b0});
    @(posedge clk); #0.5;
    chk("R10", "end rising edge", {61'h0, done, busy, asN}, {61'h0, 1'b1, 1'b0, 1'b0});
    @(negedge clk); #0.5;
    chk("R10", "end falling edge", {61'h0, asN, csN, oeN}, {61'h0, 1'b1, 1'b1, 1'b1});

    // R11: request raised mid-access is dropped
    begin
      int doneCnt = 0;
      int busyCnt = 0;
      logic [31:0] expRd;
      expRd = {mem[0], mem[1], mem[2], mem[3]};
      curPortB = 1;
      reqValid = 1'b1; reqAddr = 32'h0; reqSize = 2'b00; cfgPortW = 2'b01; cfgWaits = 4'd1;
      nextSample();
      reqValid = 1'b0;
      for (int c = 0; c < 16; c++) begin
        if (c == 2) begin
          reqValid = 1'b1; reqAddr = 32'h3C; reqSize = 2'b01;
        end else begin
          reqValid = 1'b0;
        end
        busyCnt += busy;
        doneCnt += done;
        if (done) chk("R11", "dropped request rdata", {32'h0, doneRdata}, {32'h0, expRd});
        nextSample();
      end
      chk("R11", "done pulses", 64'(doneCnt), 64'd1);
      chk("R11", "busy cycles", 64'(busyCnt), 64'd8);
      chk("R11", "idle strobes", {62'h0, asN, tsN}, {62'h0, 1'b1, 1'b1});
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule